// File: doc/BRIEF.md
# DMA Channel Sequencer

This block sequences a single DMA channel. Software loads source and destination addresses, a unit count and their backup copies through a simple register write port, then sets the channel enable. While the global enable input is high and no stop flag is raised, the sequencer waits for a request, from an internal auto-request or from an external request line. For each request it issues one transfer unit on an abstract handshake: `xfer_req` stays high with the current addresses until the memory side answers with `xfer_ack`. After each completed unit the sequencer steps the addresses and the count.

Three counting modes exist. Normal mode stops when the count runs out. Repeat mode reloads addresses and count from the backups and keeps running. It can raise a half-way flag, and that flag can keep the channel running past the end flag. Reload mode runs only the low byte of the count register and refills it from bits 23:16. In cycle-steal operation the bus is released after every unit. In burst operation it is held between units.

States: `ST_IDLE` (bus released, waiting for start), `ST_XFER` (unit in flight), `ST_GAP` (burst only: bus held for one cycle while the next unit is decided). Transitions: IDLE→XFER on start; XFER→IDLE on ack with error, or on ack in cycle-steal; XFER→GAP on ack in burst; GAP→XFER when the channel may continue; GAP→IDLE otherwise.

Top module: `dma_chan_seq`

## Requirements
- R1: A unit starts only when all of these hold: the channel enable (control bit 0) and `master_en` are 1, the address-error and NMI flags are 0, the end flag is 0 (or the R7 exception applies), the count is nonzero (in reload mode, its low byte), and a request is present.
- R2: Each unit acked without error decrements the count by one. It also steps each address by its own 2-bit mode field (source control bits 9:8, destination bits 11:10; 0 fixed, 1 increment, 2 decrement, 3 fixed). The step is 1 << the unit-size field (control bits 13:12).
- R3: Once `nmi_in` has set the NMI flag, an ack with `xfer_err` has set the address-error flag, or an enable is cleared, no further unit starts. A unit in flight still completes. An errored unit leaves the addresses and the count unchanged.
- R4: In normal mode (control bits 3:2 = 0) a count that reaches 0 sets the end flag (status bit 0) and the channel stops. `irq` is high while the end flag and the end-interrupt enable (control bit 6) are both 1.
- R5: In repeat mode (mode 1) a count that reaches 0 sets the end flag and reloads the count and both addresses from their backups.
- R6: In repeat mode with the half interrupt enable (control bit 7) at 1, a count that becomes half of the backup count (rounded down) sets the half flag (status bit 1). `irq` is also high while both are 1.
- R7: In repeat mode the channel keeps running with the end flag at 1 as long as the half enable is 1 and the half flag is 0.
- R8: In reload mode (mode 2) only bits 7:0 of the count decrement. When they reach 0 they refill from bits 23:16, and both addresses reload from their backups.
- R9: With auto-request (control bit 1) a request is always present. Otherwise `ext_req` is sampled as a level, except in burst (control bit 4) with edge detect (control bit 5). There a rising edge arms a run that continues without further requests.
- R10: `bus_hold` is high while a unit is in flight. In cycle-steal it drops in the cycle after each ack. In burst it stays high in that cycle, and it drops after an errored unit.
- R11: Status flags (bit 0 end, bit 1 half, bit 2 address error, bit 3 NMI) are sticky. A write to select 7 clears each flag whose data bit is 0 and leaves the flags whose bits are 1. A flag set by hardware in the same cycle stays set.
- R12: After reset no unit is requested, the bus is released, all flags and `irq` are 0, and the count reads 0.
- R13: Write selects: 0 source, 1 destination, 2 count, 3 source backup, 4 destination backup, 5 count backup, 6 control, 7 status. The count and the current addresses are readable at `cnt_val`, `xfer_src` and `xfer_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_en | input | 1 | Global enable shared by all channels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| ext_req | input | 1 | External transfer request |
| nmi_in | input | 1 | NMI event, sets the NMI flag |
| xfer_ack | input | 1 | Unit completed by the memory side |
| xfer_err | input | 1 | Address error, valid with `xfer_ack` |
| xfer_req | output | 1 | Unit request, held until ack |
| xfer_src | output | 32 | Current source address |
| xfer_dst | output | 32 | Current destination address |
| xfer_size | output | 2 | Unit size as log2 bytes |
| bus_hold | output | 1 | Channel holds the bus |
| cnt_val | output | 24 | Current count |
| end_flag | output | 1 | Transfer-end flag |
| half_flag | output | 1 | Half-way flag |
| aerr_flag | output | 1 | Address-error flag |
| nmi_flag | output | 1 | NMI flag |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle. One is a software write to the status register that clears every flag. The other is the final acked unit that sets the end flag. The bench drives the clearing write on the exact edge that takes the ack, then expects the end flag to read 1 afterwards. It also writes the control register with the enable cleared on the same edge as an ack, and expects that unit to count but no later unit to start. Random trials in normal and repeat modes, with random address modes, unit sizes and ack delays, are compared unit by unit against a bench model.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        XM_NORMAL = 2'd0,
        XM_REPEAT = 2'd1,
        XM_RELOAD = 2'd2,
        XM_SPARE  = 2'd3
    } xmode_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_KEEP  = 2'd3
    } amode_e;

    // Control word, least significant field last
    typedef struct packed {
        logic [1:0] unit;
        amode_e     dst_am;
        amode_e     src_am;
        logic       half_ie;
        logic       end_ie;
        logic       edge_det;
        logic       burst;
        xmode_e     mode;
        logic       auto_req;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } st_e;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_SBK  = 3'd3;
    localparam logic [2:0] SEL_DBK  = 3'd4;
    localparam logic [2:0] SEL_CBK  = 3'd5;
    localparam logic [2:0] SEL_CTRL = 3'd6;
    localparam logic [2:0] SEL_STAT = 3'd7;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  amode_e            mode_i,
    input  logic [1:0]        unit_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] step;

    always_comb begin
        step = {{(ADDR_W-1){1'b0}}, 1'b1} << unit_i;
        unique case (mode_i)
            AM_INC:  addr_o = addr_i + step;
            AM_DEC:  addr_o = addr_i - step;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic auto_req,
    input  logic edge_mode,
    input  logic consume,
    output logic req
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= ext_req;
            pend_q <= edge_mode & ((ext_req & ~prev_q) | (pend_q & ~consume));
        end
    end

    always_comb req = auto_req | (edge_mode ? pend_q : ext_req);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_req,
    input  logic              nmi_in,
    input  logic              xfer_ack,
    input  logic              xfer_err,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [1:0]        xfer_size,
    output logic              bus_hold,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              end_flag,
    output logic              half_flag,
    output logic              aerr_flag,
    output logic              nmi_flag,
    output logic              irq
);
    localparam int LO_W    = 8;
    localparam int RLD_LSB = 16;
    localparam int RLD_MSB = RLD_LSB + LO_W - 1;

    st_e               state_q, state_d;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] src_q, dst_q, sbk_q, dbk_q, src_nx, dst_nx;
    logic [CNT_W-1:0]  cnt_q, cbk_q, cnt_dec;
    logic [LO_W-1:0]   lo_dec;
    logic              end_q, half_q, aerr_q, nmi_q;

    logic is_rep, is_rld, half_ie_on, burst_on, edge_mode;
    logic cnt_nz, end_ok, go_ok, req, start;
    logic unit_done, unit_ok, wrap_cnt, wrap_lo, hit_half, reload_addr;
    logic wr_stat, set_end, set_half;

    dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr_i(src_q), .mode_i(ctrl_q.src_am), .unit_i(ctrl_q.unit), .addr_o(src_nx));
    dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr_i(dst_q), .mode_i(ctrl_q.dst_am), .unit_i(ctrl_q.unit), .addr_o(dst_nx));

    dma_req_detect u_req (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .auto_req(ctrl_q.auto_req),
        .edge_mode(edge_mode), .consume(start), .req(req));

    always_comb begin
        is_rep     = (ctrl_q.mode == XM_REPEAT);
        is_rld     = (ctrl_q.mode == XM_RELOAD);
        half_ie_on = ctrl_q.half_ie;
        burst_on   = ctrl_q.burst;
        edge_mode  = ctrl_q.burst & ctrl_q.edge_det & ~ctrl_q.auto_req;
        cnt_nz     = is_rld ? (cnt_q[LO_W-1:0] != '0) : (cnt_q != '0);
        end_ok     = ~end_q | (is_rep & ctrl_q.half_ie & ~half_q);
        go_ok      = ctrl_q.en & master_en & ~aerr_q & ~nmi_q & end_ok & cnt_nz;
        start      = (state_q == ST_IDLE) & go_ok & req;
        unit_done  = (state_q == ST_XFER) & xfer_ack;
        unit_ok    = unit_done & ~xfer_err;
        cnt_dec    = cnt_q - 1'b1;
        lo_dec     = cnt_q[LO_W-1:0] - 1'b1;
        wrap_cnt   = ~is_rld & (cnt_dec == '0);
        wrap_lo    = is_rld & (lo_dec == '0);
        hit_half   = is_rep & ctrl_q.half_ie & (cnt_dec == (cbk_q >> 1));
        reload_addr = (wrap_cnt & is_rep) | wrap_lo;
        wr_stat    = wr_en & (wr_sel == SEL_STAT);
        set_end    = unit_ok & wrap_cnt;
        set_half   = unit_ok & hit_half;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_XFER;
            ST_XFER: if (xfer_ack) state_d = (xfer_err || !ctrl_q.burst) ? ST_IDLE : ST_GAP;
            ST_GAP:  state_d = (go_ok && (req || edge_mode)) ? ST_XFER : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registers: software write first, unit update overrides
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0; dst_q <= '0; sbk_q <= '0; dbk_q <= '0;
            cnt_q <= '0; cbk_q <= '0; ctrl_q <= '0;
            end_q <= 1'b0; half_q <= 1'b0; aerr_q <= 1'b0; nmi_q <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SRC:  src_q  <= wr_data[ADDR_W-1:0];
                    SEL_DST:  dst_q  <= wr_data[ADDR_W-1:0];
                    SEL_CNT:  cnt_q  <= wr_data[CNT_W-1:0];
                    SEL_SBK:  sbk_q  <= wr_data[ADDR_W-1:0];
                    SEL_DBK:  dbk_q  <= wr_data[ADDR_W-1:0];
                    SEL_CBK:  cbk_q  <= wr_data[CNT_W-1:0];
                    SEL_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    default: ;
                endcase
            end
            if (unit_ok) begin
                src_q <= reload_addr ? sbk_q : src_nx;
                dst_q <= reload_addr ? dbk_q : dst_nx;
                if (is_rld)
                    cnt_q[LO_W-1:0] <= wrap_lo ? cnt_q[RLD_MSB:RLD_LSB] : lo_dec;
                else
                    cnt_q <= (wrap_cnt && is_rep) ? cbk_q : cnt_dec;
            end
            end_q  <= (end_q  & ~(wr_stat & ~wr_data[0])) | set_end;
            half_q <= (half_q & ~(wr_stat & ~wr_data[1])) | set_half;
            aerr_q <= (aerr_q & ~(wr_stat & ~wr_data[2])) | (unit_done & xfer_err);
            nmi_q  <= (nmi_q  & ~(wr_stat & ~wr_data[3])) | nmi_in;
        end
    end

    // outputs
    always_comb begin
        xfer_req  = (state_q == ST_XFER);
        bus_hold  = (state_q != ST_IDLE);
        xfer_src  = src_q;
        xfer_dst  = dst_q;
        xfer_size = ctrl_q.unit;
        cnt_val   = cnt_q;
        end_flag  = end_q;
        half_flag = half_q;
        aerr_flag = aerr_q;
        nmi_flag  = nmi_q;
        irq       = (end_q & ctrl_q.end_ie) | (half_q & ctrl_q.half_ie);
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             master_en,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic             xfer_req,
    input logic             xfer_ack,
    input logic             xfer_err,
    input logic             bus_hold,
    input logic [CNT_W-1:0] cnt_val,
    input logic             end_flag,
    input logic             half_flag,
    input logic             aerr_flag,
    input logic             nmi_flag,
    input logic             is_rep,
    input logic             is_rld,
    input logic             half_ie_on,
    input logic             burst_on
);
    p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> $past(master_en) && !$past(aerr_flag) && !$past(nmi_flag));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack && !xfer_err && !is_rld && cnt_val > 1
        |=> cnt_val == $past(cnt_val) - 1'b1);

    p_halt_on_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (aerr_flag || nmi_flag) && !xfer_req |=> !xfer_req);

    p_err_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack && xfer_err && !wr_en |=> $stable(cnt_val));

    p_end_from_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> $past(xfer_req && xfer_ack && !xfer_err));

    p_half_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_flag) |-> $past(is_rep && half_ie_on));

    p_cs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack && !burst_on |=> !bus_hold);

    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req);

    p_end_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        end_flag && !(wr_en && wr_sel == 3'd7) |=> end_flag);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_err(xfer_err), .bus_hold(bus_hold),
    .cnt_val(cnt_val), .end_flag(end_flag), .half_flag(half_flag), .aerr_flag(aerr_flag),
    .nmi_flag(nmi_flag), .is_rep(is_rep), .is_rld(is_rld), .half_ie_on(half_ie_on),
    .burst_on(burst_on));

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ext_req = 1'b0;
    logic        nmi_in = 1'b0;
    logic        xfer_ack = 1'b0;
    logic        xfer_err = 1'b0;
    logic        xfer_req, bus_hold, end_flag, half_flag, aerr_flag, nmi_flag, irq;
    logic [31:0] xfer_src, xfer_dst;
    logic [1:0]  xfer_size;
    logic [23:0] cnt_val;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // bench model
    logic [31:0] m_src, m_dst, m_sbk, m_dbk;
    logic [23:0] m_cnt, m_cbk;
    bit m_end, m_half, m_aerr, m_nmi, m_master, m_req;
    bit b_en, b_auto, b_burst, b_edge, b_eie, b_hie;
    logic [1:0] b_mode, b_sam, b_dam, b_unit;

    dma_chan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_req(ext_req), .nmi_in(nmi_in), .xfer_ack(xfer_ack),
        .xfer_err(xfer_err), .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_size(xfer_size), .bus_hold(bus_hold), .cnt_val(cnt_val), .end_flag(end_flag),
        .half_flag(half_flag), .aerr_flag(aerr_flag), .nmi_flag(nmi_flag), .irq(irq));

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word();
        return {18'd0, b_unit, b_dam, b_sam, b_hie, b_eie, b_edge, b_burst, b_mode, b_auto, b_en};
    endfunction

    function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] am, input logic [1:0] u);
        case (am)
            2'd1: return a + (32'd1 << u);
            2'd2: return a - (32'd1 << u);
            default: return a;
        endcase
    endfunction

    function automatic bit model_go();
        bit nz = (b_mode == 2'd2) ? (m_cnt[7:0] != 0) : (m_cnt != 0);
        bit eok = !m_end || (b_mode == 2'd1 && b_hie && !m_half);
        return b_en && m_master && !m_aerr && !m_nmi && eok && nz && m_req;
    endfunction

    task automatic model_unit(input bit err);
        logic [23:0] nc;
        logic [7:0]  lo;
        if (err) begin m_aerr = 1; return; end
        m_src = step(m_src, b_sam, b_unit);
        m_dst = step(m_dst, b_dam, b_unit);
        if (b_mode == 2'd2) begin
            lo = m_cnt[7:0] - 8'd1;
            if (lo == 0) begin lo = m_cnt[23:16]; m_src = m_sbk; m_dst = m_dbk; end
            m_cnt[7:0] = lo;
        end else begin
            nc = m_cnt - 24'd1;
            if (b_mode == 2'd1 && b_hie && nc == (m_cbk >> 1)) m_half = 1;
            if (nc == 0) begin
                m_end = 1;
                if (b_mode == 2'd1) begin nc = m_cbk; m_src = m_sbk; m_dst = m_dbk; end
            end
            m_cnt = nc;
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " end"},  end_flag,  m_end);
        chk({tag, " half"}, half_flag, m_half);
        chk({tag, " aerr"}, aerr_flag, m_aerr);
        chk({tag, " nmi"},  nmi_flag,  m_nmi);
        chk({tag, " irq"},  irq, (m_end && b_eie) || (m_half && b_hie));
    endtask

    task automatic setup(input logic [31:0] s, d, sb, db, input logic [23:0] c, cb);
        b_en = 0;
        wr(3'd6, ctrl_word());
        wr(3'd7, 32'd0);
        m_end = 0; m_half = 0; m_aerr = 0; m_nmi = 0;
        wr(3'd0, s); wr(3'd1, d); wr(3'd2, {8'd0, c});
        wr(3'd3, sb); wr(3'd4, db); wr(3'd5, {8'd0, cb});
        m_src = s; m_dst = d; m_sbk = sb; m_dbk = db; m_cnt = c; m_cbk = cb;
        b_en = 1;
        wr(3'd6, ctrl_word());
    endtask

    // serves units as the memory side and checks each against the model
    task automatic run(input int nmi_at, input int err_at, input int clr_at,
                       input int stop_at, output int units);
        int idle = 0;
        bit e;
        units = 0;
        while (idle < 6 && units < 200) begin
            @(negedge clk);
            if (xfer_req) begin
                idle = 0;
                chk("R1 start allowed", 64'(1), 64'(model_go()));
                chk("R2 src addr", xfer_src, m_src);
                chk("R2 dst addr", xfer_dst, m_dst);
                repeat ($urandom_range(0, 2)) @(negedge clk);
                e = (units == err_at);
                xfer_ack = 1; xfer_err = e;
                if (units == nmi_at) begin nmi_in = 1; m_nmi = 1; end
                if (units == clr_at) begin
                    wr_en = 1; wr_sel = 3'd7; wr_data = 32'd0;
                    m_end = 0; m_half = 0; m_aerr = 0; m_nmi = 0;
                end
                if (units == stop_at) begin
                    b_en = 0; wr_en = 1; wr_sel = 3'd6; wr_data = ctrl_word();
                end
                @(negedge clk);
                xfer_ack = 0; xfer_err = 0; nmi_in = 0; wr_en = 0;
                model_unit(e);
                units++;
                chk("R2 count", cnt_val, m_cnt);
                chk_flags("R4 R5 R6 R11 flags");
                chk("R10 bus hold after ack", bus_hold, b_burst && !e);
            end else begin
                idle++;
            end
        end
        chk("R1 R3 channel halted", 64'(model_go()), 64'(0));
        chk("R10 bus released when halted", bus_hold, 0);
    endtask

    initial begin
        int u;
        logic [23:0] c, cb;
        void'($urandom(32'd20240611));
        b_en = 0; b_auto = 1; b_burst = 0; b_edge = 0; b_eie = 1; b_hie = 0;
        b_mode = 0; b_sam = 1; b_dam = 1; b_unit = 0;
        m_master = 1; m_req = 1;
        m_end = 0; m_half = 0; m_aerr = 0; m_nmi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 xfer_req", xfer_req, 0);
        chk("R12 bus_hold", bus_hold, 0);
        chk("R12 count", cnt_val, 0);
        chk("R12 flags", {end_flag, half_flag, aerr_flag, nmi_flag, irq}, 0);

        // R13 register map and R11 write-one keeps flags clear
        wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h9abc_def0); wr(3'd2, 32'h0000_0abc);
        chk("R13 src readback", xfer_src, 32'h1234_5678);
        chk("R13 dst readback", xfer_dst, 32'h9abc_def0);
        chk("R13 count readback", cnt_val, 24'h000abc);
        wr(3'd7, 32'hf);
        chk("R11 write ones sets nothing", {end_flag, half_flag, aerr_flag, nmi_flag}, 0);

        // R1 master enable gate, then release
        master_en = 0; m_master = 0;
        setup(32'h100, 32'h200, 32'h0, 32'h0, 24'd3, 24'd3);
        run(-1, -1, -1, -1, u);
        chk("R1 no unit with master off", u, 0);
        master_en = 1; m_master = 1;
        run(-1, -1, -1, -1, u);
        chk("R4 normal run length", u, 3);

        // R9 level request
        b_auto = 0; m_req = 0; ext_req = 0;
        setup(32'h400, 32'h800, 32'h0, 32'h0, 24'd4, 24'd4);
        run(-1, -1, -1, -1, u);
        chk("R9 no unit with level low", u, 0);
        ext_req = 1; m_req = 1;
        run(-1, -1, -1, -1, u);
        chk("R9 level run length", u, 4);
        ext_req = 0; m_req = 0;

        // R9 edge request in burst: one pulse drives the whole run
        b_burst = 1; b_edge = 1; b_sam = 2; b_unit = 2;
        setup(32'h1000, 32'h2000, 32'h0, 32'h0, 24'd5, 24'd5);
        repeat (3) @(negedge clk);
        chk("R9 no unit before edge", xfer_req, 0);
        ext_req = 1; m_req = 1;
        @(negedge clk);
        ext_req = 0;
        run(-1, -1, -1, -1, u);
        chk("R9 edge burst run length", u, 5);
        b_edge = 0; b_auto = 1;

        // R3 NMI during burst: unit in flight completes, then stop
        setup(32'h3000, 32'h4000, 32'h0, 32'h0, 24'd10, 24'd10);
        run(3, -1, -1, -1, u);
        chk("R3 nmi stop length", u, 4);
        chk("R3 nmi count left", cnt_val, 24'd6);

        // R3 address error: no update, stop
        b_burst = 1;
        setup(32'h5000, 32'h6000, 32'h0, 32'h0, 24'd5, 24'd5);
        run(-1, 1, -1, -1, u);
        chk("R3 error stop length", u, 2);
        chk("R3 error count kept", cnt_val, 24'd4);

        // R3 enable cleared on an ack edge
        b_burst = 0;
        setup(32'h7000, 32'h7100, 32'h0, 32'h0, 24'd8, 24'd8);
        run(-1, -1, -1, 2, u);
        chk("R3 enable clear stop length", u, 3);

        // R11 clear write on the final ack edge: hardware set wins
        setup(32'h7200, 32'h7300, 32'h0, 32'h0, 24'd2, 24'd2);
        run(-1, -1, 1, -1, u);
        chk("R11 end survives same-cycle clear", end_flag, 1);

        // R5 R6 R7 repeat with half interrupt
        b_mode = 1; b_hie = 1; b_sam = 1; b_dam = 0; b_unit = 0;
        setup(32'h1000, 32'h2000, 32'h1000, 32'h2000, 24'd6, 24'd6);
        run(-1, -1, -1, -1, u);
        chk("R7 repeat runs past end until half", u, 6);
        chk("R5 count reloaded", cnt_val, 24'd6);
        chk("R5 src reloaded", xfer_src, 32'h1000);
        wr(3'd7, 32'h1); m_half = 0;
        chk("R11 end kept by bit 1", end_flag, 1);
        run(-1, -1, -1, -1, u);
        chk("R7 resumes with end set", u, 3);
        chk("R6 half set again", half_flag, 1);

        // R8 reload mode: low byte refills from bits 23:16
        b_mode = 2; b_hie = 0; b_sam = 1; b_dam = 2; b_unit = 1;
        setup(32'h8000, 32'h9000, 32'h8800, 32'h9900, 24'h030002, 24'd0);
        run(-1, -1, -1, 6, u);
        chk("R8 reload run length", u, 7);
        chk("R8 low byte state", cnt_val, 24'h030001);

        // random trials in normal and repeat modes
        for (int t = 0; t < 24; t++) begin
            b_mode = $urandom_range(0, 1);
            b_hie = $urandom_range(0, 1);
            b_eie = $urandom_range(0, 1);
            b_burst = $urandom_range(0, 1);
            b_sam = $urandom_range(0, 3);
            b_dam = $urandom_range(0, 3);
            b_unit = $urandom_range(0, 3);
            c = $urandom_range(1, 8);
            cb = $urandom_range(1, 8);
            setup($urandom, $urandom, $urandom, $urandom, c, cb);
            run(-1, -1, -1, -1, u);
            chk("R2 R4 R5 random trial ran", 64'(u > 0), 64'(1));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule